// File: doc/BRIEF.md
# Column-Parallel Pixel Cluster Finder

This block sits behind a column-parallel sensor readout. It receives one whole row of 5-bit pixel samples at a time, one sample per column, and looks for charge clusters. Every 2×2 group of pixels, two adjacent columns in two consecutive rows, is summed. The sum is compared with one threshold that applies at every position. A group whose sum is above the threshold marks a 7×7 window of pixels around it for readout.

Incoming rows wait in a short line buffer until no later row can still mark them. Each released row is then scanned, and only its marked pixels leave the block. Each one goes out as a (row, column, value) record through a small FIFO with a valid/ready handshake. The target occupancy is about 1%. Quiet frames therefore produce very few records.

The frame height is a parameter. Once the last row of a frame has arrived, the block releases its remaining buffered rows by itself. A frame-start pulse restarts the row count and discards all rows and marks still pending.

Top module: `pixclust_top`

## Requirements
- R1: The 2×2 sum at position (r, c) covers columns c and c+1 of rows r-1 and r. It is 7 bits wide, and it fires only when it is strictly greater than `thresh`. A sum equal to the threshold does not fire, and row 0 forms no sum.
- R2: A sum that fires at (r, c) marks rows r-4 to r+2 and columns c-3 to c+3, a 7×7 window. The window is clipped at the array edges, so a hit in a corner marks fewer pixels.
- R3: Windows that overlap merge. Each marked pixel is emitted exactly once, and records come out in ascending row order, ascending column within a row.
- R4: Each record puts the row index on `out_row`, the column index on `out_col` and the pixel's sample on `out_val`. A record is taken when `out_valid` and `out_ready` are both high, and it stays stable while `out_ready` is low.
- R5: Pixels that are not marked are never emitted. A frame in which no sum fires produces no records.
- R6: `frame_start` clears the row counter, the buffered rows and every pending mark. Pixels of a partly received frame that are still buffered are never emitted.
- R7: After row NROWS-1 arrives, the block releases the last four buffered rows with no further input. Rows that arrive after the frame's last row are ignored until the next `frame_start`.
- R8: A marked pixel that finds the FIFO full is dropped, and so is one still waiting when the next row is released. Either case sets `overflow`, which stays high until reset. The records already queued are delivered intact and in order.
- R9: During and after reset `out_valid` and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | synchronous active-low reset |
| frame_start | input | 1 | restart frame: clears row counter and pending marks |
| row_valid | input | 1 | a row of samples is present on `row_data` |
| row_data | input | NCOLS*5 | samples, column c in bits [5c+4:5c] |
| thresh | input | 7 | global threshold for the 2×2 sums |
| out_valid | output | 1 | a record is available |
| out_ready | input | 1 | consumer accepts the record |
| out_row | output | $clog2(NROWS) | record row index |
| out_col | output | $clog2(NCOLS) | record column index |
| out_val | output | 5 | record pixel sample |
| overflow | output | 1 | sticky: a marked pixel was dropped |

## Verification
The bench aims at a sum exactly equal to the threshold. A design using greater-or-equal would emit a full window there. It places hits in opposite corners, so a design without edge clipping would wrap marks into the far columns or emit rows that do not exist. Two overlapping windows must appear once per pixel, where a naive design would emit duplicates. A frame restarted halfway must emit nothing from its buffered rows, and a design that missed clearing would leak those rows into the next frame. Holding the FIFO stalled through a dense window must raise the sticky overflow and still deliver an ordered prefix of the records; a design that overwrote queued entries would corrupt that prefix.

// File: rtl/pixclust_pkg.sv
// Shared constants and types for the cluster finder.
// Assumes 5-bit flash ADC samples and a 7x7 marking window.
package pixclust_pkg;
    localparam int PIX_W     = 5;
    localparam int SUM_W     = PIX_W + 2;
    localparam int WIN_HALF  = 3;
    localparam int LAG_ROWS  = WIN_HALF + 1;
    localparam int HIST_ROWS = 2 * WIN_HALF;
    typedef logic [PIX_W-1:0] pix_t;
endpackage

// File: rtl/pixclust_kernel.sv
// Forms every 2x2 sum from the current and previous rows, thresholds each one,
// and dilates the hits horizontally by WIN_HALF columns with edge clipping.
// Assumes NCOLS >= 2; output is zero when enable is low.
module pixclust_kernel
    import pixclust_pkg::*;
#(
    parameter int NCOLS = 16
) (
    input  logic [NCOLS*PIX_W-1:0] cur_row,
    input  logic [NCOLS*PIX_W-1:0] prev_row,
    input  logic [SUM_W-1:0]       thresh,
    input  logic                   enable,
    output logic [NCOLS-1:0]       hit_mask
);
    logic [NCOLS-2:0] fire;

    for (genvar k = 0; k < NCOLS - 1; k++) begin : g_sum
        logic [SUM_W-1:0] sum;
        // Purpose: 2x2 sum over columns k, k+1 of both rows.
        always_comb begin
            sum = SUM_W'(cur_row[k*PIX_W +: PIX_W])
                + SUM_W'(cur_row[(k+1)*PIX_W +: PIX_W])
                + SUM_W'(prev_row[k*PIX_W +: PIX_W])
                + SUM_W'(prev_row[(k+1)*PIX_W +: PIX_W]);
        end
        assign fire[k] = enable && (sum > thresh);
    end

    for (genvar j = 0; j < NCOLS; j++) begin : g_dil
        logic acc;
        // Purpose: OR of the hits whose window covers column j.
        always_comb begin
            acc = 1'b0;
            for (int k = 0; k < NCOLS - 1; k++) begin
                if ((k >= j - WIN_HALF) && (k <= j + WIN_HALF)) begin
                    acc = acc | fire[k];
                end
            end
        end
        assign hit_mask[j] = acc;
    end
endmodule

// File: rtl/pixclust_linebuf.sv
// Delays pixel rows by LAG_ROWS steps and keeps the last HIST_ROWS dilated hit
// masks. The mark for the row leaving the buffer is the OR of the current mask
// and the whole history, i.e. the vertical dilation.
// Assumes the caller zeroes in_mask on steps that form no sum.
module pixclust_linebuf
    import pixclust_pkg::*;
#(
    parameter int NCOLS = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   step,
    input  logic [NCOLS*PIX_W-1:0] in_row,
    input  logic [NCOLS-1:0]       in_mask,
    output logic [NCOLS*PIX_W-1:0] prev_row,
    output logic [NCOLS*PIX_W-1:0] emit_row,
    output logic [NCOLS-1:0]       emit_mask
);
    logic [NCOLS*PIX_W-1:0] rows [LAG_ROWS];
    logic [NCOLS-1:0]       hist [HIST_ROWS];

    // Purpose: shift the pixel rows and hit masks on every row step.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            for (int i = 0; i < LAG_ROWS; i++) rows[i] <= '0;
            for (int i = 0; i < HIST_ROWS; i++) hist[i] <= '0;
        end else if (step) begin
            rows[0] <= in_row;
            for (int i = 1; i < LAG_ROWS; i++) rows[i] <= rows[i-1];
            hist[0] <= in_mask;
            for (int i = 1; i < HIST_ROWS; i++) hist[i] <= hist[i-1];
        end
    end

    assign prev_row = rows[0];
    assign emit_row = rows[LAG_ROWS-1];

    // Purpose: merge all masks whose window reaches the outgoing row.
    always_comb begin
        emit_mask = in_mask;
        for (int i = 0; i < HIST_ROWS; i++) emit_mask = emit_mask | hist[i];
    end
endmodule

// File: rtl/pixclust_scan.sv
// Turns one marked row into sparse records, lowest column first, one per cycle.
// A record that meets a full FIFO is dropped; bits still pending when a new row
// loads are dropped too. Both report through lost.
module pixclust_scan
    import pixclust_pkg::*;
#(
    parameter int NCOLS = 16,
    parameter int ROW_W = 4,
    localparam int COL_W = $clog2(NCOLS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   load,
    input  logic [NCOLS-1:0]       load_mask,
    input  logic [ROW_W-1:0]       load_row,
    input  logic [NCOLS*PIX_W-1:0] load_vals,
    input  logic                   fifo_full,
    output logic                   busy,
    output logic                   push,
    output logic [ROW_W-1:0]       push_row,
    output logic [COL_W-1:0]       push_col,
    output pix_t                   push_val,
    output logic                   lost
);
    logic [NCOLS-1:0]       mask;
    logic [NCOLS*PIX_W-1:0] vals;
    logic [ROW_W-1:0]       row;
    logic [COL_W-1:0]       pick;
    logic                   found;
    logic [NCOLS-1:0]       rest;

    // Purpose: priority-encode the lowest marked column.
    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int i = 0; i < NCOLS; i++) begin
            if (mask[i] && !found) begin
                pick  = COL_W'(i);
                found = 1'b1;
            end
        end
    end

    assign busy     = |mask;
    assign rest     = mask & ~(NCOLS'(1) << pick);
    assign push     = busy && !fifo_full;
    assign push_row = row;
    assign push_col = pick;
    assign push_val = vals[pick*PIX_W +: PIX_W];
    assign lost     = (busy && fifo_full) || (load && (|rest));

    // Purpose: hold the row being scanned and retire one bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            mask <= '0;
            vals <= '0;
            row  <= '0;
        end else if (load) begin
            mask <= load_mask;
            vals <= load_vals;
            row  <= load_row;
        end else if (busy) begin
            mask <= rest;
        end
    end
endmodule

// File: rtl/pixclust_fifo.sv
// Synchronous FIFO with valid/ready read side. Assumes DEPTH is a power of two
// and that the writer never writes while full.
module pixclust_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic         full,
    output logic         rd_valid,
    input  logic         rd_ready,
    output logic [W-1:0] rd_data
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [PTR_W:0]   count;
    logic             do_wr, do_rd;

    assign full     = (count == (PTR_W+1)'(DEPTH));
    assign rd_valid = (count != '0);
    assign rd_data  = mem[rd_ptr];
    assign do_wr    = wr_en && !full;
    assign do_rd    = rd_valid && rd_ready;

    // Purpose: store written entries.
    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    // Purpose: advance pointers and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_wr) wr_ptr <= wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= rd_ptr + 1'b1;
            if (do_wr && !do_rd)      count <= count + 1'b1;
            else if (!do_wr && do_rd) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/pixclust_top.sv
// Column-parallel cluster finder: 2x2 threshold search, 7x7 marking window,
// line-buffered release and sparse readout through a FIFO.
// Assumes NROWS > 4, rows spaced by at least NCOLS+1 cycles for lossless
// readout, and frame_start not issued while the end-of-frame release runs.
module pixclust_top
    import pixclust_pkg::*;
#(
    parameter int NCOLS      = 16,
    parameter int NROWS      = 64,
    parameter int FIFO_DEPTH = 8,
    localparam int ROW_W = $clog2(NROWS),
    localparam int COL_W = $clog2(NCOLS),
    localparam int CNT_W = $clog2(NROWS + LAG_ROWS + 1),
    localparam int REC_W = ROW_W + COL_W + PIX_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   frame_start,
    input  logic                   row_valid,
    input  logic [NCOLS*PIX_W-1:0] row_data,
    input  logic [SUM_W-1:0]       thresh,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [ROW_W-1:0]       out_row,
    output logic [COL_W-1:0]       out_col,
    output logic [PIX_W-1:0]       out_val,
    output logic                   overflow
);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(NROWS - 1);
    localparam logic [CNT_W-1:0] ROWS_C = CNT_W'(NROWS);
    localparam logic [CNT_W-1:0] LAG_C  = CNT_W'(LAG_ROWS);
    localparam int               FL_W   = $clog2(LAG_ROWS + 1);

    logic [CNT_W-1:0]       step_cnt;
    logic [FL_W-1:0]        flush_cnt;
    logic                   step_real, step_virt, step, load;
    logic                   scan_busy, scan_push, scan_lost, fifo_full;
    logic [NCOLS-1:0]       hit_mask, emit_mask;
    logic [NCOLS*PIX_W-1:0] prev_row, emit_row, buf_in;
    logic [ROW_W-1:0]       push_row;
    logic [COL_W-1:0]       push_col;
    pix_t                   push_val;
    logic [REC_W-1:0]       rd_rec;

    assign step_real = row_valid && !frame_start && (step_cnt < ROWS_C);
    assign step_virt = !frame_start && (flush_cnt != '0) && !scan_busy;
    assign step      = step_real || step_virt;
    assign load      = step && (step_cnt >= LAG_C);
    assign buf_in    = step_real ? row_data : '0;

    // Purpose: count row steps and run the end-of-frame release.
    always_ff @(posedge clk) begin
        if (!rst_n || frame_start) begin
            step_cnt  <= '0;
            flush_cnt <= '0;
        end else begin
            if (step) step_cnt <= step_cnt + 1'b1;
            if (step_real && (step_cnt == LAST_C)) flush_cnt <= FL_W'(LAG_ROWS);
            else if (step_virt)                    flush_cnt <= flush_cnt - 1'b1;
        end
    end

    // Purpose: sticky record-loss flag.
    always_ff @(posedge clk) begin
        if (!rst_n)         overflow <= 1'b0;
        else if (scan_lost) overflow <= 1'b1;
    end

    pixclust_kernel #(.NCOLS(NCOLS)) u_kernel (
        .cur_row  (row_data),
        .prev_row (prev_row),
        .thresh   (thresh),
        .enable   (step_real && (step_cnt != '0)),
        .hit_mask (hit_mask)
    );

    pixclust_linebuf #(.NCOLS(NCOLS)) u_linebuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (frame_start),
        .step      (step),
        .in_row    (buf_in),
        .in_mask   (hit_mask),
        .prev_row  (prev_row),
        .emit_row  (emit_row),
        .emit_mask (emit_mask)
    );

    pixclust_scan #(.NCOLS(NCOLS), .ROW_W(ROW_W)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (frame_start),
        .load      (load),
        .load_mask (emit_mask),
        .load_row  (ROW_W'(step_cnt - LAG_C)),
        .load_vals (emit_row),
        .fifo_full (fifo_full),
        .busy      (scan_busy),
        .push      (scan_push),
        .push_row  (push_row),
        .push_col  (push_col),
        .push_val  (push_val),
        .lost      (scan_lost)
    );

    pixclust_fifo #(.W(REC_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (scan_push),
        .wr_data  ({push_row, push_col, push_val}),
        .full     (fifo_full),
        .rd_valid (out_valid),
        .rd_ready (out_ready),
        .rd_data  (rd_rec)
    );

    assign {out_row, out_col, out_val} = rd_rec;
endmodule

// File: rtl/pixclust_sva.sv
// Checker for pixclust_top, attached by bind below.
module pixclust_sva #(
    parameter int NROWS = 64,
    parameter int ROW_W = 6,
    parameter int COL_W = 4,
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_start,
    input logic             out_valid,
    input logic             out_ready,
    input logic [ROW_W-1:0] out_row,
    input logic [COL_W-1:0] out_col,
    input logic [4:0]       out_val,
    input logic             overflow,
    input logic [CNT_W-1:0] step_cnt
);
    // R4: a stalled record stays put
    a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable({out_row, out_col, out_val})));

    // R8: loss flag is sticky
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R9: reset empties the output and clears the flag
    a_r9_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && !overflow));

    // R2: records never name a row outside the array
    a_r2_row_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (32'(out_row) < NROWS));

    // R6: frame start restarts the row count
    a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (step_cnt == '0));
endmodule

bind pixclust_top pixclust_sva #(
    .NROWS(NROWS), .ROW_W(ROW_W), .COL_W(COL_W), .CNT_W(CNT_W)
) u_sva (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_row(out_row), .out_col(out_col), .out_val(out_val),
    .overflow(overflow), .step_cnt(step_cnt)
);

// File: tb/pixclust_top_tb.sv
module pixclust_top_tb;
    localparam int NC = 16;
    localparam int NR = 12;
    localparam int FD = 16;
    localparam int RW = $clog2(NR);
    localparam int CW = $clog2(NC);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            frame_start = 1'b0;
    logic            row_valid = 1'b0;
    logic [NC*5-1:0] row_data = '0;
    logic [6:0]      thresh = '0;
    logic            out_valid;
    logic            out_ready = 1'b1;
    logic [RW-1:0]   out_row;
    logic [CW-1:0]   out_col;
    logic [4:0]      out_val;
    logic            overflow;

    always #5 clk = ~clk;

    pixclust_top #(.NCOLS(NC), .NROWS(NR), .FIFO_DEPTH(FD)) u_dut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .row_valid(row_valid), .row_data(row_data), .thresh(thresh),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_row(out_row), .out_col(out_col), .out_val(out_val),
        .overflow(overflow)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int frm [NR][NC];
    int exp_r [256]; int exp_c [256]; int exp_v [256]; int n_exp;
    int got_r [256]; int got_c [256]; int got_v [256]; int n_got;

    // collect accepted records away from the active edge
    always @(negedge clk) begin
        if (rst_n && out_valid && out_ready && n_got < 256) begin
            got_r[n_got] = int'(out_row);
            got_c[n_got] = int'(out_col);
            got_v[n_got] = int'(out_val);
            n_got = n_got + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic clear_frm();
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NC; c++) frm[r][c] = 0;
    endtask

    task automatic set_kernel(input int r, input int c, input int v);
        frm[r-1][c] = v; frm[r-1][c+1] = v; frm[r][c] = v; frm[r][c+1] = v;
    endtask

    // expected records from the requirements: rows received < nsent, emitted rows <= lim
    task automatic build_exp(input int thr, input int nsent, input int lim);
        bit mk [NR][NC];
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NC; c++) mk[r][c] = 0;
        for (int r = 1; r < nsent; r++)
            for (int c = 0; c < NC - 1; c++)
                if (frm[r-1][c] + frm[r-1][c+1] + frm[r][c] + frm[r][c+1] > thr)
                    for (int y = r - 4; y <= r + 2; y++)
                        for (int x = c - 3; x <= c + 3; x++)
                            if (y >= 0 && y < NR && x >= 0 && x < NC) mk[y][x] = 1;
        n_exp = 0;
        for (int r = 0; r <= lim; r++)
            for (int c = 0; c < NC; c++)
                if (mk[r][c]) begin
                    exp_r[n_exp] = r; exp_c[n_exp] = c; exp_v[n_exp] = frm[r][c];
                    n_exp++;
                end
    endtask

    task automatic pulse_start();
        @(posedge clk); #1 frame_start = 1'b1;
        @(posedge clk); #1 frame_start = 1'b0;
        n_got = 0;
    endtask

    task automatic send_row(input int r);
        @(posedge clk); #1;
        row_valid = 1'b1;
        for (int c = 0; c < NC; c++) row_data[c*5 +: 5] = 5'(frm[r][c]);
        @(posedge clk); #1 row_valid = 1'b0;
        repeat (20) @(posedge clk);
    endtask

    task automatic send_rows(input int n);
        for (int r = 0; r < n; r++) send_row(r);
    endtask

    // compare collected records with the expected list
    task automatic compare(input string req, input int want_n);
        int bad = 0;
        chk(n_got == want_n, {req, " record count"}, n_got, want_n);
        for (int i = 0; i < n_got && i < n_exp; i++) begin
            if (bad == 0 && (got_r[i] != exp_r[i] || got_c[i] != exp_c[i] || got_v[i] != exp_v[i])) begin
                bad = 1;
                chk(0, {req, " record (row*100+col) at index"},
                    got_r[i]*100 + got_c[i], exp_r[i]*100 + exp_c[i]);
            end
        end
        if (bad == 0) chk(1, req, 0, 0);
    endtask

    task automatic t_reset();
        chk(out_valid == 1'b0, "R9 out_valid after reset", int'(out_valid), 0);
        chk(overflow == 1'b0, "R9 overflow after reset", int'(overflow), 0);
    endtask

    task automatic t_empty();
        clear_frm(); thresh = 7'd10;
        pulse_start(); send_rows(NR); repeat (150) @(posedge clk);
        chk(n_got == 0, "R5 empty frame emits nothing", n_got, 0);
    endtask

    task automatic t_single();
        clear_frm(); thresh = 7'd20;
        frm[5][7] = 5; frm[5][8] = 5; frm[6][7] = 5; frm[6][8] = 6;
        pulse_start(); send_rows(NR); repeat (150) @(posedge clk);
        build_exp(20, NR, NR - 1);
        chk(n_exp == 49, "R2 model full window size", n_exp, 49);
        compare("R1 R2 R4 single cluster", 49);
    endtask

    task automatic t_equal();
        clear_frm(); thresh = 7'd20;
        frm[5][7] = 5; frm[5][8] = 5; frm[6][7] = 5; frm[6][8] = 5;
        pulse_start(); send_rows(NR); repeat (150) @(posedge clk);
        chk(n_got == 0, "R1 sum equal to threshold does not fire", n_got, 0);
    endtask

    task automatic t_corners();
        clear_frm(); thresh = 7'd100;
        set_kernel(1, 0, 31);
        set_kernel(11, 14, 31);
        pulse_start(); send_rows(NR); repeat (150) @(posedge clk);
        build_exp(100, NR, NR - 1);
        compare("R2 R7 corner clipping and end-of-frame release", n_exp);
        // rows after the frame's last row are ignored
        for (int r = 0; r < NR; r++)
            for (int c = 0; c < NC; c++) frm[r][c] = 31;
        send_rows(2); repeat (100) @(posedge clk);
        chk(n_got == n_exp, "R7 rows after frame end ignored", n_got, n_exp);
    endtask

    task automatic t_overlap();
        clear_frm(); thresh = 7'd30;
        set_kernel(4, 3, 10);
        set_kernel(6, 5, 10);
        pulse_start(); send_rows(NR); repeat (150) @(posedge clk);
        build_exp(30, NR, NR - 1);
        compare("R3 overlapping windows merge", n_exp);
        chk(n_exp < 98, "R3 merged count below two windows", n_exp, 97);
    endtask

    task automatic t_restart();
        clear_frm(); thresh = 7'd50;
        set_kernel(3, 8, 31);
        pulse_start(); send_rows(7);
        build_exp(50, 7, 2);
        @(posedge clk); #1 frame_start = 1'b1;
        @(posedge clk); #1 frame_start = 1'b0;
        clear_frm();
        send_rows(NR); repeat (150) @(posedge clk);
        compare("R6 restart discards pending rows", n_exp);
    endtask

    task automatic t_overflow();
        clear_frm(); thresh = 7'd20;
        frm[5][7] = 5; frm[5][8] = 5; frm[6][7] = 5; frm[6][8] = 6;
        out_ready = 1'b0;
        pulse_start(); send_rows(NR); repeat (150) @(posedge clk);
        @(negedge clk);
        chk(overflow == 1'b1, "R8 overflow set on full FIFO", int'(overflow), 1);
        chk(out_valid == 1'b1, "R4 record held while stalled", int'(out_valid), 1);
        build_exp(20, NR, NR - 1);
        @(posedge clk); #1 out_ready = 1'b1;
        repeat (60) @(posedge clk);
        compare("R8 queued prefix delivered", FD);
        chk(overflow == 1'b1, "R8 overflow stays set", int'(overflow), 1);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_empty();
        t_single();
        t_equal();
        t_corners();
        t_overlap();
        t_restart();
        t_overflow();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule